// File: doc/BRIEF.md
# MDIO Management Frame Slave Decoder

This block is the device-side end of a two-wire serial management bus. A host toggles a management clock and a data line by hand. The block samples the data line on each rising clock edge. It recognises the idle preamble, the start bit, the operation code, the device address and the register number. It then either collects sixteen bits of write data or puts sixteen bits of read data onto the line. Both the management clock and the incoming data are already synchronous to the system clock, and all state changes happen on system clock edges.

The back end is a plain register port. The block presents the decoded device address and register number, the collected write data and a one-cycle write strobe. It takes read data back combinationally. A local device address input selects which frames belong to this device. A write to any other address is dropped. A read to any other address returns all ones. The line driver has two outputs, a data bit and an output enable, which together form a tristate pair.

Top module: `mdio_slave`

## Requirements
- R1: While the synchronous active-low reset is asserted, and after it is released, the output enable, data output, write strobe and start warning are all low, and the decoder waits for a preamble.
- R2: A frame begins only on the first rising clock edge that samples the data line low after at least PRE_BITS rising edges have been counted since the decoder last entered its idle state. A low sampled before that count is reached is ignored and only advances the count.
- R3: After the frame start, the decoder shifts in a one-bit start field, a two-bit opcode, a five-bit device address and a five-bit register number, each most significant bit first on rising edges. The decoded address and register number appear on the register port, and the device address is compared with the local address input.
- R4: When the start field is sampled as 0, the start warning output pulses high for exactly one cycle, and decoding of the frame continues unchanged.
- R5: Turnaround takes two rising edges. On the second one, if the opcode is binary 10 (read), the output enable goes high with the data output low.
- R6: During a read, sixteen data bits are driven most significant bit first. Each bit appears on the first system clock edge after a falling management clock edge.
- R7: A read whose device address differs from the local address returns 16'hFFFF.
- R8: A write (opcode binary 01) to the local address gives exactly one one-cycle write strobe, in the cycle after the sixteenth data rising edge, carrying the sixteen bits received most significant bit first. There is no strobe before that edge.
- R9: A write to another address, or a frame with opcode 00 or 11, gives no write strobe and never drives the line.
- R10: On the sixteenth data rising edge the output enable is released and the decoder returns to idle. A new frame then needs a fresh preamble count.
- R11: Whenever the output enable is low, the data output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc_i | input | 1 | Management clock, sampled in the system clock domain |
| mdio_i | input | 1 | Management data line as seen at the pin |
| local_addr_i | input | 5 | Device address this block answers to |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe_o | output | 1 | Line drive enable |
| start_warn_o | output | 1 | One-cycle pulse when the start field is sampled as 0 |
| reg_phy_addr_o | output | 5 | Device address decoded from the frame |
| reg_num_o | output | 5 | Register number decoded from the frame |
| reg_wdata_o | output | 16 | Write data for the register port |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 16 | Read data for the register named by reg_num_o |

## Verification
The bench builds the block with its default parameters: a preamble threshold of 32, sixteen-bit data and five-bit address and register fields. It runs the management clock at four system clocks per half period. With a threshold of 32, the bench can run a frame whose low bit comes after exactly 31 idle bits, as well as ordinary frames after exactly 32, so the counting boundary is tested from both sides. Sixteen-bit data means every bit position of the read shifter and the write collector is checked against known patterns. The bench drives the local address input to two different values during the run, so the present and absent cases are exercised for reads and for writes.

// File: rtl/mdio_slave_pkg.sv
// Package: shared decoder state encoding and opcode values for the
// management frame slave. Assumes nothing beyond IEEE 1800-2017.
package mdio_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_PRE = 3'd0,
        ST_START    = 3'd1,
        ST_OPCODE   = 3'd2,
        ST_DEVADDR  = 3'd3,
        ST_REGNUM   = 3'd4,
        ST_TURN     = 3'd5,
        ST_DATA     = 3'd6
    } mdio_state_e;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;

endpackage

// File: rtl/mdio_edge_detect.sv
// Module: management clock edge detector.
// Registers the sampled management clock once and reports rising and
// falling transitions as single-cycle pulses. Assumes mdc_i is already
// synchronous to clk; the pulses are combinational against the register.
module mdio_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    output logic rise_o,
    output logic fall_o
);

    logic mdc_q;

    // Keep the previous clock level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
        end else begin
            mdc_q <= mdc_i;
        end
    end

    // Transition pulses, valid until the next system clock edge.
    always_comb begin
        rise_o = mdc_i & ~mdc_q;
        fall_o = ~mdc_i & mdc_q;
    end

endmodule

// File: rtl/mdio_frame_decoder.sv
// Module: frame field decoder.
// Walks through idle preamble, start, opcode, device address, register
// number, turnaround and data on rising management clock edges. It shares
// one bit counter across all phases. Assumes rise_i is a single-cycle pulse
// and that PHY_W, REG_W and DATA_W are each at least 2.
module mdio_frame_decoder
    import mdio_slave_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int DATA_W   = 16,
    parameter int PHY_W    = 5,
    parameter int REG_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              mdio_i,
    output logic [1:0]        opcode_o,
    output logic [PHY_W-1:0]  phy_o,
    output logic [REG_W-1:0]  reg_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              start_bad_o,
    output logic              turn_end_o,
    output logic              data_end_o
);

    localparam int MAX_CNT = (PRE_BITS > DATA_W) ? PRE_BITS : DATA_W;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] PRE_LIM  = CNT_W'(PRE_BITS);
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(1);
    localparam logic [CNT_W-1:0] PHY_LAST = CNT_W'(PHY_W - 1);
    localparam logic [CNT_W-1:0] REG_LAST = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0] TRN_LAST = CNT_W'(1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

    mdio_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase-end events seen by the neighbouring driver and commit logic.
    always_comb begin
        start_bad_o = rise_i && (state_q == ST_START) && !mdio_i;
        turn_end_o  = rise_i && (state_q == ST_TURN) && (cnt_q == TRN_LAST);
        data_end_o  = rise_i && (state_q == ST_DATA) && (cnt_q == DAT_LAST);
    end

    // Phase sequencing, bit counting and field shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE_PRE;
            cnt_q    <= '0;
            opcode_o <= '0;
            phy_o    <= '0;
            reg_o    <= '0;
            wdata_o  <= '0;
        end else if (rise_i) begin
            case (state_q)
                ST_IDLE_PRE: begin
                    if ((cnt_q >= PRE_LIM) && !mdio_i) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end else if (cnt_q < PRE_LIM) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_START: begin
                    state_q <= ST_OPCODE;
                    cnt_q   <= '0;
                end
                ST_OPCODE: begin
                    opcode_o <= {opcode_o[0], mdio_i};
                    if (cnt_q == OPC_LAST) begin
                        state_q <= ST_DEVADDR;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_DEVADDR: begin
                    phy_o <= {phy_o[PHY_W-2:0], mdio_i};
                    if (cnt_q == PHY_LAST) begin
                        state_q <= ST_REGNUM;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_REGNUM: begin
                    reg_o <= {reg_o[REG_W-2:0], mdio_i};
                    if (cnt_q == REG_LAST) begin
                        state_q <= ST_TURN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_TURN: begin
                    if (cnt_q == TRN_LAST) begin
                        state_q <= ST_DATA;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    wdata_o <= {wdata_o[DATA_W-2:0], mdio_i};
                    if (cnt_q == DAT_LAST) begin
                        state_q <= ST_IDLE_PRE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE_PRE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mdio_read_driver.sv
// Module: read data line driver.
// Takes the read word when turnaround ends on a read. It holds the line
// low until the first falling management clock edge, then presents one bit
// per falling edge, most significant first. It lets go of the line when the
// data phase ends. Assumes the event inputs are single-cycle pulses.
module mdio_read_driver #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              release_i,
    output logic              oe_o,
    output logic              bit_o
);

    logic [DATA_W-1:0] shift_q;

    // Drive enable, output bit and outgoing shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_o    <= 1'b0;
            bit_o   <= 1'b0;
            shift_q <= '0;
        end else if (load_i) begin
            oe_o    <= 1'b1;
            bit_o   <= 1'b0;
            shift_q <= word_i;
        end else if (release_i) begin
            oe_o  <= 1'b0;
            bit_o <= 1'b0;
        end else if (fall_i && oe_o) begin
            bit_o   <= shift_q[DATA_W-1];
            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/mdio_slave.sv
// Module: management frame slave, top level.
// Connects the edge detector, the frame decoder and the read driver. It
// decides whether the frame's device address belongs to this block and
// issues the register write strobe one cycle after the last data bit.
// Assumes mdc_i and mdio_i are synchronous to clk and that the register
// port returns reg_rdata_i combinationally for reg_num_o.
module mdio_slave
    import mdio_slave_pkg::*;
#(
    parameter int PRE_BITS = 32,
    parameter int DATA_W   = 16,
    parameter int PHY_W    = 5,
    parameter int REG_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_i,
    input  logic              mdio_i,
    input  logic [PHY_W-1:0]  local_addr_i,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              start_warn_o,
    output logic [PHY_W-1:0]  reg_phy_addr_o,
    output logic [REG_W-1:0]  reg_num_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);

    logic              mdc_rise;
    logic              mdc_fall;
    logic [1:0]        opcode;
    logic              start_bad;
    logic              turn_end;
    logic              data_end;
    logic              addr_hit;
    logic              read_load;
    logic [DATA_W-1:0] read_word;

    mdio_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc_i),
        .rise_o (mdc_rise),
        .fall_o (mdc_fall)
    );

    mdio_frame_decoder #(
        .PRE_BITS (PRE_BITS),
        .DATA_W   (DATA_W),
        .PHY_W    (PHY_W),
        .REG_W    (REG_W)
    ) u_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (mdc_rise),
        .mdio_i      (mdio_i),
        .opcode_o    (opcode),
        .phy_o       (reg_phy_addr_o),
        .reg_o       (reg_num_o),
        .wdata_o     (reg_wdata_o),
        .start_bad_o (start_bad),
        .turn_end_o  (turn_end),
        .data_end_o  (data_end)
    );

    // Address match and read word selection (all ones when absent).
    always_comb begin
        addr_hit  = (reg_phy_addr_o == local_addr_i);
        read_load = turn_end && (opcode == OPC_READ);
        read_word = addr_hit ? reg_rdata_i : {DATA_W{1'b1}};
    end

    mdio_read_driver #(
        .DATA_W (DATA_W)
    ) u_driver (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (mdc_fall),
        .load_i    (read_load),
        .word_i    (read_word),
        .release_i (data_end),
        .oe_o      (mdio_oe_o),
        .bit_o     (mdio_o)
    );

    // Write strobe and start warning, one cycle after their edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we_o     <= 1'b0;
            start_warn_o <= 1'b0;
        end else begin
            reg_we_o     <= data_end && (opcode == OPC_WRITE) && addr_hit;
            start_warn_o <= start_bad;
        end
    end

endmodule

// File: rtl/mdio_slave_checker.sv
// Module: property checker for the management frame slave, bound to every
// instance of the top module. Observes ports only.
module mdio_slave_checker (
    input logic clk,
    input logic rst_n,
    input logic mdc_i,
    input logic mdio_o,
    input logic mdio_oe_o,
    input logic start_warn_o,
    input logic reg_we_o
);

    assert_we_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    assert_we_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> $past(mdc_i));

    assert_warn_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_warn_o |=> !start_warn_o);

    assert_turn_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> ($past(mdc_i) && !mdio_o));

    assert_shift_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe_o && $past(mdio_oe_o) && (mdio_o != $past(mdio_o))) |-> !$past(mdc_i));

    assert_release_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe_o) |-> $past(mdc_i));

    assert_quiet_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe_o |-> !mdio_o);

endmodule

bind mdio_slave mdio_slave_checker u_mdio_slave_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .mdc_i        (mdc_i),
    .mdio_o       (mdio_o),
    .mdio_oe_o    (mdio_oe_o),
    .start_warn_o (start_warn_o),
    .reg_we_o     (reg_we_o)
);

// File: tb/mdio_slave_bench.sv
// Bench: a behavioural per-cycle model compared on every clock, plus
// directed frame checks against a small register file.
module mdio_slave_bench;

    localparam int PRE = 32;
    localparam int H   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        mdio = 1'b1;
    logic [4:0]  local_addr = 5'h03;
    logic        mdio_o, mdio_oe_o, start_warn_o, reg_we_o;
    logic [4:0]  reg_phy_addr_o, reg_num_o;
    logic [15:0] reg_wdata_o, reg_rdata_i;
    logic [15:0] mem [0:31];

    int total = 0;
    int bad = 0;
    int we_cnt = 0;
    int oe_rise_cnt = 0;
    int warn_cnt = 0;
    bit done = 0;
    bit started = 0;

    always #10 clk = ~clk;

    mdio_slave u_mdio_slave (
        .clk            (clk),
        .rst_n          (rst_n),
        .mdc_i          (mdc),
        .mdio_i         (mdio),
        .local_addr_i   (local_addr),
        .mdio_o         (mdio_o),
        .mdio_oe_o      (mdio_oe_o),
        .start_warn_o   (start_warn_o),
        .reg_phy_addr_o (reg_phy_addr_o),
        .reg_num_o      (reg_num_o),
        .reg_wdata_o    (reg_wdata_o),
        .reg_we_o       (reg_we_o),
        .reg_rdata_i    (reg_rdata_i)
    );

    assign reg_rdata_i = mem[reg_num_o];

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 16'h8000 | 16'(i * 37);
    end

    // Register file writes and event counters.
    logic oe_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_we_o) begin
                mem[reg_num_o] <= reg_wdata_o;
                we_cnt++;
            end
            if (start_warn_o) warn_cnt++;
            if (mdio_oe_o && !oe_prev) oe_rise_cnt++;
        end
        oe_prev <= mdio_oe_o;
    end

    // Behavioural reference model.
    int          ph, cnt;
    bit          pm, r, f;
    logic [15:0] msh, mwd;
    logic [1:0]  mop;
    logic [4:0]  mad, mrg;
    logic        moe, mout, mwe, mwarn;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            ph = 0; cnt = 0; pm = 0; moe = 0; mout = 0; mwe = 0; mwarn = 0;
            msh = 0; mwd = 0; mop = 0; mad = 0; mrg = 0;
        end else begin
            r = mdc && !pm;
            f = !mdc && pm;
            pm = mdc;
            mwe = 0;
            mwarn = 0;
            if (f && moe) begin
                mout = msh[15];
                msh = msh << 1;
            end
            if (r) begin
                case (ph)
                    0: if (cnt >= PRE && !mdio) begin ph = 1; cnt = 0; end
                       else if (cnt < PRE) cnt++;
                    1: begin if (!mdio) mwarn = 1; ph = 2; cnt = 0; end
                    2: begin mop = {mop[0], mdio}; cnt++; if (cnt == 2) begin ph = 3; cnt = 0; end end
                    3: begin mad = {mad[3:0], mdio}; cnt++; if (cnt == 5) begin ph = 4; cnt = 0; end end
                    4: begin mrg = {mrg[3:0], mdio}; cnt++; if (cnt == 5) begin ph = 5; cnt = 0; end end
                    5: begin
                        cnt++;
                        if (cnt == 2) begin
                            ph = 6; cnt = 0;
                            if (mop == 2'b10) begin
                                moe = 1; mout = 0;
                                msh = (mad == local_addr) ? mem[mrg] : 16'hFFFF;
                            end
                        end
                    end
                    default: begin
                        mwd = {mwd[14:0], mdio}; cnt++;
                        if (cnt == 16) begin
                            ph = 0; cnt = 0; moe = 0; mout = 0;
                            if (mop == 2'b01 && mad == local_addr) mwe = 1;
                        end
                    end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(mdio_oe_o == moe, "R5 model drive enable", 32'(mdio_oe_o), 32'(moe));
            chk(mdio_o == mout, "R6 model data out", 32'(mdio_o), 32'(mout));
            chk(reg_we_o == mwe, "R8 model write strobe", 32'(reg_we_o), 32'(mwe));
            chk(start_warn_o == mwarn, "R4 model start warning", 32'(start_warn_o), 32'(mwarn));
            if (mwe) begin
                chk(reg_wdata_o == mwd, "R8 model write data", 32'(reg_wdata_o), 32'(mwd));
                chk(reg_phy_addr_o == mad, "R3 model address", 32'(reg_phy_addr_o), 32'(mad));
                chk(reg_num_o == mrg, "R3 model register", 32'(reg_num_o), 32'(mrg));
            end
        end
    end

    task automatic half_bit();
        repeat (H) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        mdc = 1'b0; mdio = b; half_bit();
        mdc = 1'b1; half_bit();
    endtask

    task automatic bit_in(output logic b);
        mdc = 1'b0; mdio = 1'b1; half_bit();
        b = mdio_o;
        mdc = 1'b1; half_bit();
    endtask

    task automatic frame(input int pre, input logic st, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, output logic [15:0] rd,
                         output logic turn_low);
        rd = 16'h0;
        turn_low = 1'b0;
        for (int i = 0; i < pre; i++) bit_out(1'b1);
        bit_out(1'b0);
        bit_out(st);
        for (int i = 1; i >= 0; i--) bit_out(op[i]);
        for (int i = 4; i >= 0; i--) bit_out(pa[i]);
        for (int i = 4; i >= 0; i--) bit_out(ra[i]);
        if (op == 2'b10) begin
            bit_out(1'b1);
            mdc = 1'b0; mdio = 1'b1; half_bit();
            mdc = 1'b1;
            repeat (2) @(negedge clk);
            turn_low = mdio_oe_o && !mdio_o;
            repeat (H - 2) @(negedge clk);
            for (int i = 15; i >= 0; i--) bit_in(rd[i]);
        end else begin
            bit_out(1'b1);
            bit_out(1'b0);
            for (int i = 15; i >= 0; i--) bit_out(wd[i]);
        end
        mdc = 1'b0; mdio = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic tl;
        int w0, o0, k0;
        repeat (5) @(negedge clk);
        chk(!mdio_oe_o && !mdio_o, "R1 reset line idle", {mdio_oe_o, mdio_o}, 0);
        chk(!reg_we_o && !start_warn_o, "R1 reset strobes idle", {reg_we_o, start_warn_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mdio_oe_o && !reg_we_o, "R1 after release", {mdio_oe_o, reg_we_o}, 0);

        // R8 write to the local address
        w0 = we_cnt;
        frame(PRE, 1'b1, 2'b01, 5'h03, 5'd7, 16'hA5C3, rd, tl);
        chk(we_cnt == w0 + 1, "R8 one write strobe", we_cnt, w0 + 1);
        chk(mem[7] == 16'hA5C3, "R8 register written", mem[7], 16'hA5C3);

        // R5 R6 read back
        frame(PRE, 1'b1, 2'b10, 5'h03, 5'd7, 16'h0, rd, tl);
        chk(rd == 16'hA5C3, "R6 read data", rd, 16'hA5C3);
        chk(tl, "R5 turnaround driven low", tl, 1);
        chk(!mdio_oe_o, "R10 drive released", mdio_oe_o, 0);
        frame(PRE, 1'b1, 2'b10, 5'h03, 5'd2, 16'h0, rd, tl);
        chk(rd == mem[2], "R6 read preset pattern", rd, mem[2]);

        // R7 absent address read
        frame(PRE, 1'b1, 2'b10, 5'h09, 5'd7, 16'h0, rd, tl);
        chk(rd == 16'hFFFF, "R7 absent read all ones", rd, 16'hFFFF);

        // R9 absent write and unused opcodes
        w0 = we_cnt; o0 = oe_rise_cnt;
        frame(PRE, 1'b1, 2'b01, 5'h09, 5'd7, 16'h1234, rd, tl);
        frame(PRE, 1'b1, 2'b00, 5'h03, 5'd7, 16'h1111, rd, tl);
        frame(PRE, 1'b1, 2'b11, 5'h03, 5'd7, 16'h2222, rd, tl);
        chk(we_cnt == w0, "R9 no strobe", we_cnt, w0);
        chk(oe_rise_cnt == o0, "R9 no drive", oe_rise_cnt, o0);
        chk(mem[7] == 16'hA5C3, "R9 register untouched", mem[7], 16'hA5C3);

        // R4 bad start bit still decodes
        k0 = warn_cnt; w0 = we_cnt;
        frame(PRE, 1'b0, 2'b01, 5'h03, 5'd4, 16'h0F0F, rd, tl);
        chk(warn_cnt == k0 + 1, "R4 warning pulse", warn_cnt, k0 + 1);
        chk(mem[4] == 16'h0F0F, "R4 frame still committed", mem[4], 16'h0F0F);

        // R2 low after 31 idle bits is ignored
        w0 = we_cnt; o0 = oe_rise_cnt; k0 = warn_cnt;
        for (int i = 0; i < PRE - 1; i++) bit_out(1'b1);
        bit_out(1'b0);
        for (int i = 0; i < 40; i++) bit_out(1'b1);
        chk(we_cnt == w0 && oe_rise_cnt == o0, "R2 short preamble no frame", we_cnt, w0);
        chk(warn_cnt == k0, "R2 short preamble no start", warn_cnt, k0);
        frame(PRE, 1'b1, 2'b01, 5'h03, 5'd5, 16'h5AA5, rd, tl);
        chk(mem[5] == 16'h5AA5, "R2 exact preamble accepted", mem[5], 16'h5AA5);

        // R10 no fresh preamble: frame straight after a frame is ignored
        w0 = we_cnt;
        frame(0, 1'b1, 2'b01, 5'h03, 5'd6, 16'hDEAD, rd, tl);
        chk(we_cnt == w0, "R10 back to back ignored", we_cnt, w0);

        // R3 new local address
        local_addr = 5'h1E;
        frame(PRE, 1'b1, 2'b01, 5'h1E, 5'd1, 16'h7777, rd, tl);
        frame(PRE, 1'b1, 2'b10, 5'h1E, 5'd1, 16'h0, rd, tl);
        chk(rd == 16'h7777, "R3 new address read back", rd, 16'h7777);
        chk(reg_phy_addr_o == 5'h1E && reg_num_o == 5'd1, "R3 decoded fields",
            {reg_phy_addr_o, reg_num_o}, {5'h1E, 5'd1});
        frame(PRE, 1'b1, 2'b10, 5'h03, 5'd1, 16'h0, rd, tl);
        chk(rd == 16'hFFFF, "R7 old address now absent", rd, 16'hFFFF);
        chk(!mdio_oe_o && !mdio_o, "R11 idle line low", {mdio_oe_o, mdio_o}, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule